// File: doc/BRIEF.md
# Watchdog Timer with Stop-Mode Run Control

This block is a free-running watchdog counter that software must service at regular intervals. Servicing is a two-write unlock: a first key byte, then a second key byte. When the counter reaches the end of its programmed period without a service, the block raises a reset request. The request is also raised at once when a service write carries a wrong byte or puts the keys out of order. The request holds until an external acknowledge clears it. A three-bit rate field picks a power-of-two period, and a rate of zero switches the watchdog off.

The block works in a single clock domain. Three candidate count sources arrive as one-cycle tick strobes: an auxiliary low-power source, an internal RC source and an oscillator source. Two select bits choose among them. A combinational rule table decides whether the counter keeps counting or freezes while the system is stopped, and it reports which source that decision belongs to.

When the auxiliary source is selected, entering and leaving stop each take two auxiliary ticks, to model resynchronisation. After leaving stop, a guard window of two more auxiliary ticks defers any new stop request. This holds for full stop and pseudo stop alike. With the other sources, stop follows the request one cycle later.

Top module: `cop_watchdog`

## Requirements
- R1: With rate r in 1..7, the reset request rises after 2^(2+2r) ticks of the selected source, counted from the last service, acknowledge or reset. The period is 16 ticks for r=1 and 64 ticks for r=2.
- R2: A write of 0x55 followed by a write of 0xAA restarts the period from zero.
- R3: Any other write raises the reset request on the clock edge that takes the write. This covers any other byte, 0xAA with no 0x55 pending, and a second 0x55.
- R4: The reset request stays high until rst_ack. Service writes are ignored while it is high. rst_ack clears the request, the counter and any pending first key.
- R5: A rate of 0 stops the counter, and service writes are then ignored, so no reset request is raised.
- R6: src_sel=1x selects aux_tick, 01 selects osc_tick and 00 selects rc_tick. Only the selected strobe advances the counter.
- R7: With src_sel[1]=1, stop_run = !aux_off_in_stop and stop_src = 2'b10 (auxiliary), whatever the other configuration inputs are.
- R8: With src_sel[1]=0, stop_run is 1 only when pseudo_stop, osc_on_in_pstop, src_sel[0], osc_en and osc_stable are all 1. stop_src is 2'b01 (oscillator) when src_sel[0], osc_en and osc_stable are all 1, and 2'b00 (RC) otherwise.
- R9: While stop_active is high and stop_run is low, the counter holds its value. While stop_run is high, it keeps counting.
- R10: With the auxiliary source, stop_active rises on the second aux tick after stop_req is seen and falls on the second aux tick after stop_req drops. This is the same for full and pseudo stop. With the other sources, stop_active follows stop_req one cycle later.
- R11: With the auxiliary source, stop_blocked is high for the two aux ticks that follow each stop exit. A stop request during that window takes effect only after the window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Count source select |
| aux_tick | input | 1 | Auxiliary source tick strobe |
| rc_tick | input | 1 | RC source tick strobe |
| osc_tick | input | 1 | Oscillator source tick strobe |
| rate | input | 3 | Period select; 0 disables |
| svc_wr | input | 1 | Service write strobe |
| svc_data | input | 8 | Service write byte |
| rst_ack | input | 1 | Reset request acknowledge |
| stop_req | input | 1 | System stop request |
| pseudo_stop | input | 1 | 1 = pseudo stop, 0 = full stop |
| aux_off_in_stop | input | 1 | Auxiliary source halts in stop |
| osc_on_in_pstop | input | 1 | Oscillator kept on in pseudo stop |
| osc_en | input | 1 | Oscillator enabled |
| osc_stable | input | 1 | Oscillator stable status |
| wd_reset | output | 1 | Watchdog reset request |
| stop_active | output | 1 | Stop in effect for the counter |
| stop_blocked | output | 1 | Post-exit guard window |
| stop_run | output | 1 | Counter runs in stop |
| stop_src | output | 2 | Source label for stop behaviour |

## Verification
stop_run and stop_src are combinational, so they are sampled one time step after the inputs change. Every other output is registered. A bad key sets wd_reset on the edge that takes the write. A timeout sets it on the edge of the last tick of the period, so with a tick on every cycle the bench samples it exactly N falling edges after the service completes, and also checks the cycle before. Stop transitions on the auxiliary source are sampled one edge before and at the second-tick edge. The bench drives inputs and samples outputs only on falling edges, so every sample lands on a known count of rising edges.

// File: rtl/cop_pkg.sv
package cop_pkg;
  typedef enum logic [1:0] {
    SRC_RC  = 2'b00,
    SRC_OSC = 2'b01,
    SRC_AUX = 2'b10
  } src_e;

  typedef enum logic [2:0] {
    SY_RUN,
    SY_ENTER,
    SY_STOP,
    SY_EXIT,
    SY_GUARD
  } sync_e;
endpackage

// File: rtl/cop_stop_table.sv
module cop_stop_table
  import cop_pkg::*;
(
  input  logic [1:0] src_sel,
  input  logic       pseudo_stop,
  input  logic       aux_off_in_stop,
  input  logic       osc_on_in_pstop,
  input  logic       osc_en,
  input  logic       osc_stable,
  output logic       run,
  output src_e       src
);
  logic osc_ready;

  always_comb begin
    osc_ready = src_sel[0] & osc_en & osc_stable;
    if (src_sel[1]) begin
      run = ~aux_off_in_stop;
      src = SRC_AUX;
    end else begin
      run = pseudo_stop & osc_on_in_pstop & osc_ready;
      src = osc_ready ? SRC_OSC : SRC_RC;
    end
  end
endmodule

// File: rtl/cop_stop_sync.sv
module cop_stop_sync
  import cop_pkg::*;
#(
  parameter int SYNC_TICKS  = 2,
  parameter int GUARD_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic aux_mode,
  input  logic aux_tick,
  input  logic stop_req,
  output logic stop_active,
  output logic stop_blocked
);
  localparam int KMAX = (SYNC_TICKS > GUARD_TICKS) ? SYNC_TICKS : GUARD_TICKS;
  localparam int KW   = (KMAX > 1) ? $clog2(KMAX) : 1;
  localparam logic [KW-1:0] SYNC_LAST  = KW'(SYNC_TICKS - 1);
  localparam logic [KW-1:0] GUARD_LAST = KW'(GUARD_TICKS - 1);

  sync_e         state;
  logic [KW-1:0] k;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SY_RUN;
      k     <= '0;
    end else begin
      case (state)
        SY_RUN: if (stop_req) begin
          state <= aux_mode ? SY_ENTER : SY_STOP;
          k     <= '0;
        end
        SY_ENTER: begin
          if (!stop_req) state <= SY_RUN;
          else if (!aux_mode) state <= SY_STOP;
          else if (aux_tick) begin
            if (k == SYNC_LAST) begin
              state <= SY_STOP;
              k     <= '0;
            end else k <= k + 1'b1;
          end
        end
        SY_STOP: if (!stop_req) begin
          state <= aux_mode ? SY_EXIT : SY_RUN;
          k     <= '0;
        end
        SY_EXIT: begin
          if (!aux_mode) state <= SY_RUN;
          else if (aux_tick) begin
            if (k == SYNC_LAST) begin
              state <= SY_GUARD;
              k     <= '0;
            end else k <= k + 1'b1;
          end
        end
        SY_GUARD: begin
          if (!aux_mode) state <= SY_RUN;
          else if (aux_tick) begin
            if (k == GUARD_LAST) begin
              state <= SY_RUN;
              k     <= '0;
            end else k <= k + 1'b1;
          end
        end
        default: state <= SY_RUN;
      endcase
    end
  end

  assign stop_active  = (state == SY_STOP) || (state == SY_EXIT);
  assign stop_blocked = (state == SY_GUARD);
endmodule

// File: rtl/cop_key_seq.sv
module cop_key_seq #(
  parameter int          KEY_W      = 8,
  parameter logic [KEY_W-1:0] KEY_FIRST  = 8'h55,
  parameter logic [KEY_W-1:0] KEY_SECOND = 8'hAA
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             clear,
  input  logic             wr,
  input  logic [KEY_W-1:0] data,
  output logic             svc_ok,
  output logic             svc_bad
);
  logic armed;
  logic first_ok;

  always_comb begin
    first_ok = !armed && (data == KEY_FIRST);
    svc_ok   = enable && wr && armed && (data == KEY_SECOND);
    svc_bad  = enable && wr && !first_ok && !(armed && (data == KEY_SECOND));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else if (clear) armed <= 1'b0;
    else if (enable && wr) armed <= first_ok;
  end
endmodule

// File: rtl/cop_watchdog.sv
module cop_watchdog
  import cop_pkg::*;
#(
  parameter int RATE_W      = 3,
  parameter int BASE_LOG2   = 2,
  parameter int STEP_LOG2   = 2,
  parameter int KEY_W       = 8,
  parameter logic [KEY_W-1:0] KEY_FIRST  = 8'h55,
  parameter logic [KEY_W-1:0] KEY_SECOND = 8'hAA,
  parameter int SYNC_TICKS  = 2,
  parameter int GUARD_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        src_sel,
  input  logic              aux_tick,
  input  logic              rc_tick,
  input  logic              osc_tick,
  input  logic [RATE_W-1:0] rate,
  input  logic              svc_wr,
  input  logic [KEY_W-1:0]  svc_data,
  input  logic              rst_ack,
  input  logic              stop_req,
  input  logic              pseudo_stop,
  input  logic              aux_off_in_stop,
  input  logic              osc_on_in_pstop,
  input  logic              osc_en,
  input  logic              osc_stable,
  output logic              wd_reset,
  output logic              stop_active,
  output logic              stop_blocked,
  output logic              stop_run,
  output logic [1:0]        stop_src
);
  localparam int MAX_RATE = (1 << RATE_W) - 1;
  localparam int CNT_W    = BASE_LOG2 + STEP_LOG2 * MAX_RATE;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim_mask;
  logic             enabled;
  logic             tick_sel;
  logic             tick_now;
  logic             svc_ok;
  logic             svc_bad;
  src_e             src_lbl;
  int               tap;

  cop_stop_table u_table (
    .src_sel         (src_sel),
    .pseudo_stop     (pseudo_stop),
    .aux_off_in_stop (aux_off_in_stop),
    .osc_on_in_pstop (osc_on_in_pstop),
    .osc_en          (osc_en),
    .osc_stable      (osc_stable),
    .run             (stop_run),
    .src             (src_lbl)
  );
  assign stop_src = src_lbl;

  cop_stop_sync #(
    .SYNC_TICKS  (SYNC_TICKS),
    .GUARD_TICKS (GUARD_TICKS)
  ) u_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .aux_mode     (src_sel[1]),
    .aux_tick     (aux_tick),
    .stop_req     (stop_req),
    .stop_active  (stop_active),
    .stop_blocked (stop_blocked)
  );

  cop_key_seq #(
    .KEY_W      (KEY_W),
    .KEY_FIRST  (KEY_FIRST),
    .KEY_SECOND (KEY_SECOND)
  ) u_keys (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enabled && !wd_reset),
    .clear   (rst_ack),
    .wr      (svc_wr),
    .data    (svc_data),
    .svc_ok  (svc_ok),
    .svc_bad (svc_bad)
  );

  always_comb begin
    enabled  = (rate != '0);
    tick_sel = src_sel[1] ? aux_tick : (src_sel[0] ? osc_tick : rc_tick);
    tick_now = enabled && tick_sel && (!stop_active || stop_run);
    tap      = BASE_LOG2 + STEP_LOG2 * int'(rate);
    lim_mask = {CNT_W{1'b1}} >> (CNT_W - tap);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      wd_reset <= 1'b0;
    end else if (rst_ack) begin
      cnt      <= '0;
      wd_reset <= 1'b0;
    end else if (!wd_reset) begin
      if (svc_bad) wd_reset <= 1'b1;
      else if (svc_ok) cnt <= '0;
      else if (tick_now) begin
        if ((cnt & lim_mask) == lim_mask) wd_reset <= 1'b1;
        else cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cop_watchdog_chk.sv
module cop_watchdog_chk #(
  parameter int RATE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_ack,
  input logic              wd_reset,
  input logic [RATE_W-1:0] rate,
  input logic [1:0]        src_sel,
  input logic              aux_off_in_stop,
  input logic              stop_run,
  input logic              stop_active,
  input logic              stop_blocked
);
  // R4
  reset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset && !rst_ack |=> wd_reset);

  // R4
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_ack |=> !wd_reset);

  // R5
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == '0) && !wd_reset && !rst_ack |=> !wd_reset);

  // R7
  aux_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_sel[1] |-> (stop_run == !aux_off_in_stop));

  // R11
  guard_follows_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_sel[1] && $past(src_sel[1]) && $fell(stop_active) |-> stop_blocked);

  // R11
  guard_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_blocked |-> !stop_active);
endmodule

bind cop_watchdog cop_watchdog_chk #(.RATE_W(RATE_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .rst_ack         (rst_ack),
  .wd_reset        (wd_reset),
  .rate            (rate),
  .src_sel         (src_sel),
  .aux_off_in_stop (aux_off_in_stop),
  .stop_run        (stop_run),
  .stop_active     (stop_active),
  .stop_blocked    (stop_blocked)
);

// File: tb/tb_cop_watchdog.sv
module tb_cop_watchdog;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] src_sel = 2'b01;
  logic       aux_tick = 1'b1, rc_tick = 1'b1, osc_tick = 1'b1;
  logic [2:0] rate = 3'd1;
  logic       svc_wr = 1'b0;
  logic [7:0] svc_data = 8'h00;
  logic       rst_ack = 1'b0;
  logic       stop_req = 1'b0, pseudo_stop = 1'b0, aux_off_in_stop = 1'b0;
  logic       osc_on_in_pstop = 1'b0, osc_en = 1'b0, osc_stable = 1'b0;
  logic       wd_reset, stop_active, stop_blocked, stop_run;
  logic [1:0] stop_src;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cop_watchdog dut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .aux_tick(aux_tick),
    .rc_tick(rc_tick), .osc_tick(osc_tick), .rate(rate), .svc_wr(svc_wr),
    .svc_data(svc_data), .rst_ack(rst_ack), .stop_req(stop_req),
    .pseudo_stop(pseudo_stop), .aux_off_in_stop(aux_off_in_stop),
    .osc_on_in_pstop(osc_on_in_pstop), .osc_en(osc_en), .osc_stable(osc_stable),
    .wd_reset(wd_reset), .stop_active(stop_active), .stop_blocked(stop_blocked),
    .stop_run(stop_run), .stop_src(stop_src)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_byte(input logic [7:0] b);
    svc_wr = 1'b1;
    svc_data = b;
    @(negedge clk);
    svc_wr = 1'b0;
  endtask

  task automatic service();
    wr_byte(8'h55);
    wr_byte(8'hAA);
  endtask

  task automatic ack();
    rst_ack = 1'b1;
    @(negedge clk);
    rst_ack = 1'b0;
  endtask

  function automatic logic [2:0] exp_table(input logic [1:0] sel, input logic ps,
      input logic aoff, input logic opon, input logic oen, input logic ostb);
    logic good;
    if (sel[1]) return {!aoff, 2'b10};
    good = sel[0] && oen && ostb;
    return {ps && opon && good, good ? 2'b01 : 2'b00};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic armed;
    logic exp_rst;
    logic [7:0] d;
    logic [2:0] e;
    void'($urandom(32'd20240611));
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    chk("R4 reset state wd_reset", wd_reset, 0);
    chk("R10 reset state stop_active", stop_active, 0);
    chk("R11 reset state stop_blocked", stop_blocked, 0);

    // R1 rate 1 period 16
    service();
    wait_n(15); chk("R1 rate1 before timeout", wd_reset, 0);
    wait_n(1);  chk("R1 rate1 at timeout", wd_reset, 1);
    // R4 held, service ignored
    wait_n(5); service(); wait_n(3);
    chk("R4 held until ack", wd_reset, 1);
    ack();
    chk("R4 cleared by ack", wd_reset, 0);
    wait_n(15); chk("R4 counter cleared by ack", wd_reset, 0);
    wait_n(1);  chk("R4 counter restarts after ack", wd_reset, 1);
    ack();

    // R2 service restarts period
    service(); wait_n(10); service();
    wait_n(15); chk("R2 service restarted period", wd_reset, 0);
    wait_n(1);  chk("R2 timeout after restart", wd_reset, 1);
    ack();

    // R1 rate 2 period 64
    rate = 3'd2;
    service();
    wait_n(63); chk("R1 rate2 before timeout", wd_reset, 0);
    wait_n(1);  chk("R1 rate2 at timeout", wd_reset, 1);
    ack();
    rate = 3'd1;

    // R6 only selected strobe counts
    src_sel = 2'b00; rc_tick = 1'b0;
    service();
    wait_n(40); chk("R6 unselected ticks ignored", wd_reset, 0);
    rc_tick = 1'b1;
    wait_n(15); chk("R6 rc before timeout", wd_reset, 0);
    wait_n(1);  chk("R6 rc timeout", wd_reset, 1);
    ack();
    src_sel = 2'b01;

    // R5 rate zero disables
    rate = 3'd0;
    wait_n(100); chk("R5 no timeout when disabled", wd_reset, 0);
    wr_byte(8'h13); wait_n(2);
    chk("R5 bad key ignored when disabled", wd_reset, 0);
    rate = 3'd1;

    // R3 wrong order
    wr_byte(8'hAA);
    chk("R3 second key first", wd_reset, 1);
    ack();
    wr_byte(8'h55); wr_byte(8'h55);
    chk("R3 first key twice", wd_reset, 1);
    ack();

    // R9 frozen in stop (full stop, oscillator source)
    service();
    stop_req = 1'b1;
    wait_n(40); chk("R9 frozen in stop", wd_reset, 0);
    stop_req = 1'b0;
    wait_n(15); chk("R9 resumes after stop", wd_reset, 0);
    wait_n(1);  chk("R9 timeout after resume", wd_reset, 1);
    ack();

    // R8 running in stop
    pseudo_stop = 1'b1; osc_on_in_pstop = 1'b1; osc_en = 1'b1; osc_stable = 1'b1;
    #1 chk("R8 run flag", stop_run, 1);
    chk("R8 run source osc", stop_src, 2'b01);
    service();
    stop_req = 1'b1;
    wait_n(15); chk("R8 running in stop before timeout", wd_reset, 0);
    wait_n(1);  chk("R8 running in stop timeout", wd_reset, 1);
    stop_req = 1'b0;
    ack();
    wait_n(2);

    // R10 / R11 auxiliary latency, both stop kinds
    rate = 3'd0; src_sel = 2'b10;
    for (int p = 0; p < 2; p++) begin
      pseudo_stop = p[0];
      stop_req = 1'b1;
      wait_n(2); chk("R10 entry not yet", stop_active, 0);
      wait_n(1); chk("R10 entry after 2 aux ticks", stop_active, 1);
      stop_req = 1'b0;
      wait_n(2); chk("R10 exit not yet", stop_active, 1);
      wait_n(1); chk("R10 exit after 2 aux ticks", stop_active, 0);
      chk("R11 guard open", stop_blocked, 1);
      stop_req = 1'b1;
      wait_n(1); chk("R11 request deferred", stop_active, 0);
      chk("R11 guard still open", stop_blocked, 1);
      wait_n(1); chk("R11 guard closed", stop_blocked, 0);
      wait_n(3); chk("R11 deferred entry taken", stop_active, 1);
      stop_req = 1'b0;
      wait_n(6);
      chk("R11 back to run", stop_blocked, 0);
    end
    // R10 no aux ticks, no entry
    aux_tick = 1'b0; stop_req = 1'b1;
    wait_n(10); chk("R10 entry waits for aux ticks", stop_active, 0);
    aux_tick = 1'b1;
    wait_n(2); chk("R10 entry on second tick", stop_active, 1);
    stop_req = 1'b0;
    wait_n(6);
    // R10 non-aux source, one cycle
    src_sel = 2'b01; stop_req = 1'b1;
    wait_n(1); chk("R10 non-aux entry", stop_active, 1);
    stop_req = 1'b0;
    wait_n(1); chk("R10 non-aux exit", stop_active, 0);
    chk("R10 non-aux no guard", stop_blocked, 0);

    // R7 / R8 random table sweep
    for (int i = 0; i < 64; i++) begin
      src_sel = 2'($urandom); pseudo_stop = 1'($urandom);
      aux_off_in_stop = 1'($urandom); osc_on_in_pstop = 1'($urandom);
      osc_en = 1'($urandom); osc_stable = 1'($urandom);
      #1;
      e = exp_table(src_sel, pseudo_stop, aux_off_in_stop, osc_on_in_pstop,
                    osc_en, osc_stable);
      chk(src_sel[1] ? "R7 table run" : "R8 table run", stop_run, e[2]);
      chk(src_sel[1] ? "R7 table src" : "R8 table src", stop_src, e[1:0]);
      wait_n(1);
    end

    // R2 / R3 random key writes
    src_sel = 2'b01; rate = 3'd7;
    ack();
    armed = 1'b0;
    for (int i = 0; i < 40; i++) begin
      case ($urandom % 4)
        0, 1: d = 8'h55;
        2:    d = 8'hAA;
        default: d = 8'($urandom);
      endcase
      if (!armed && d == 8'h55) begin armed = 1'b1; exp_rst = 1'b0; end
      else if (armed && d == 8'hAA) begin armed = 1'b0; exp_rst = 1'b0; end
      else exp_rst = 1'b1;
      wr_byte(d);
      chk(exp_rst ? "R3 random bad key" : "R2 random good key", wd_reset, exp_rst);
      if (exp_rst) begin
        ack();
        armed = 1'b0;
      end
      wait_n(1);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule